// File: doc/BRIEF.md
# Clock Multiplier Enable/Connect and Lock Supervisor

This block is the synchronous control side of an analog clock multiplier. Software writes an enable request, a connect request and an interrupt mask through a control strobe. It writes the multiplier and pre-divider settings through a separate configuration strobe. The block decides when the system clock may switch from the raw input clock to the multiplied clock. The multiplier itself appears only as a lock input. The glitch-free clock switch, the bus decoder and the interrupt controller sit outside this block.

Lock is taken from the analog lock input while the reference frequency is inside the range where that input can be trusted. Outside that range the input is ignored, and a start-up timer counts ticks of a free-running reference tick. When the count is reached, the multiplier is declared locked. A level-sensitive interrupt reports lock. Entering power-down drops the enable and connect requests. A 32-bit read-back word shows the settings in use and the three control/status bits.

The sequencing core is a four-state machine:
- `ST_OFF`: multiplier disabled.
- `ST_ACQUIRE`: enabled and waiting for lock.
- `ST_LOCKED`: locked but not connected.
- `ST_CONNECTED`: multiplied clock selected.

Transitions:
- `OFF→ACQUIRE`: enable seen.
- `ACQUIRE→LOCKED`: lock condition met.
- `LOCKED→CONNECTED`: connect request held.
- `CONNECTED→LOCKED`: connect request withdrawn.
- `LOCKED/CONNECTED→ACQUIRE`: the analog lock is lost while in range.
- `any→ACQUIRE`: enabled and the settings changed (restart).
- `any→OFF`: enable dropped.

Top module: `pll_lock_supervisor`

## Requirements
- R1: `clk_sel_pll` is 1 only while the enable bit, the connect bit and the lock bit in `status_word` are all 1; otherwise the raw input clock is selected (`clk_sel_pll`=0).
- R2: Connect=1 with enable=0 behaves as fully off: select 0, lock 0, interrupt 0, whatever the lock input does.
- R3: A cycle with `pwr_down`=1 clears the enable and connect bits at the next clock edge, even when a control write is presented in the same cycle.
- R4: `status_word` holds:
  - multiplier-minus-one in bits 14:0;
  - pre-divider-minus-one in bits 23:16;
  - enable in bit 24;
  - connect in bit 25;
  - lock in bit 26;
  - zeros in bit 15 and bits 31:27.
  All fields read 0 after reset.
- R5: `lock_irq` is a level equal to lock AND the interrupt-enable bit. Clearing the interrupt-enable bit masks it without changing lock or select.
- R6: With `ref_out_of_range`=0, lock is reached two cycles after enable once `pll_lock_in`=1. Loss of `pll_lock_in` returns the machine to `ST_ACQUIRE`, clearing lock and select.
- R7: With `ref_out_of_range`=1, `pll_lock_in` is ignored. Lock is declared after the start-up limit counted in `ref_tick` pulses. The limit is 200 when `ref_below_400k`=1, else `startup_ticks_long`. No ticks means no lock.
- R8: Dropping enable, or a configuration write that changes the multiplier or pre-divider value, clears lock and restarts the start-up count.
- R9: A connect request made before lock is held pending and takes effect without a further write once lock arrives.
- R10: A configuration write with values equal to those in use does not disturb lock or select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_enable | input | 1 | Enable request value |
| ctl_connect | input | 1 | Connect request value |
| ctl_irq_en | input | 1 | Lock interrupt enable value |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mult | input | 15 | Multiplier minus one |
| cfg_prediv | input | 8 | Pre-divider minus one |
| pwr_down | input | 1 | Power-down entry |
| ref_tick | input | 1 | Free-running reference tick, one cycle per pulse |
| pll_lock_in | input | 1 | Analog lock indication |
| ref_out_of_range | input | 1 | Reference frequency outside the trusted lock range |
| ref_below_400k | input | 1 | Reference frequency below 400 kHz |
| startup_ticks_long | input | 16 | Tick count equal to 500 µs |
| clk_sel_pll | output | 1 | 1 selects the multiplied clock |
| lock_irq | output | 1 | Level lock interrupt request |
| status_word | output | 32 | Read-back word |

## Verification
The hardest situation to reach from the ports is the start-up timer path, where lock must appear after a number of ticks while the analog lock input says the opposite. The stimulus holds `pll_lock_in` against the expected result and runs the tick both continuously and stopped. It samples lock inside a window below and a window above each limit. A restart through a changed configuration while lock is held must drop lock at once, whereas an identical write must not. Both writes are applied from the fully connected state.

// File: rtl/pls_pkg.sv
package pls_pkg;
    localparam int MULT_W  = 15;
    localparam int DIV_W   = 8;
    localparam int CNT_W   = 16;
    localparam int SHORT_TICKS = 200;

    typedef enum logic [1:0] {
        ST_OFF       = 2'd0,
        ST_ACQUIRE   = 2'd1,
        ST_LOCKED    = 2'd2,
        ST_CONNECTED = 2'd3
    } pls_state_e;

    typedef struct packed {
        logic             en;
        logic             conn;
        logic             irq_en;
        logic [MULT_W-1:0] mult;
        logic [DIV_W-1:0]  prediv;
    } pls_regs_t;
endpackage

// File: rtl/pls_startup_timer.sv
module pls_startup_timer
    import pls_pkg::*;
#(
    parameter int CW    = CNT_W,
    parameter int SHORT = SHORT_TICKS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clear,
    input  logic          tick,
    input  logic          use_short,
    input  logic [CW-1:0] long_limit,
    output logic          done
);
    localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT);

    logic [CW-1:0] count_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit = use_short ? SHORT_LIM : long_limit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear || !run) begin
            count_q <= '0;
        end else if (tick && (count_q < limit)) begin
            count_q <= count_q + 1'b1;
        end
    end

    always_comb begin
        done = run && !clear && (count_q >= limit);
    end
endmodule

// File: rtl/pls_ctrl_fsm.sv
module pls_ctrl_fsm
    import pls_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       conn,
    input  logic       restart,
    input  logic       lock_ok,
    input  logic       analog_mode,
    output pls_state_e state,
    output logic       acquiring,
    output logic       locked,
    output logic       connected
);
    pls_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_OFF;
        end else if (restart) begin
            state_d = ST_ACQUIRE;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = ST_ACQUIRE;
                end
                ST_ACQUIRE: begin
                    if (lock_ok) begin
                        state_d = ST_LOCKED;
                    end
                end
                ST_LOCKED: begin
                    if (analog_mode && !lock_ok) begin
                        state_d = ST_ACQUIRE;
                    end else if (conn) begin
                        state_d = ST_CONNECTED;
                    end
                end
                ST_CONNECTED: begin
                    if (analog_mode && !lock_ok) begin
                        state_d = ST_ACQUIRE;
                    end else if (!conn) begin
                        state_d = ST_LOCKED;
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        state     = state_q;
        acquiring = 1'b0;
        locked    = 1'b0;
        connected = 1'b0;
        unique case (state_q)
            ST_OFF:       ;
            ST_ACQUIRE:   acquiring = 1'b1;
            ST_LOCKED:    locked = 1'b1;
            ST_CONNECTED: begin
                locked    = 1'b1;
                connected = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pls_status_pack.sv
module pls_status_pack
    import pls_pkg::*;
(
    input  logic [MULT_W-1:0] mult,
    input  logic [DIV_W-1:0]  prediv,
    input  logic              en,
    input  logic              conn,
    input  logic              lock,
    output logic [31:0]       word
);
    always_comb begin
        word = '0;
        word[MULT_W-1:0] = mult;
        word[16 +: DIV_W] = prediv;
        word[24] = en;
        word[25] = conn;
        word[26] = lock;
    end
endmodule

// File: rtl/pll_lock_supervisor.sv
module pll_lock_supervisor
    import pls_pkg::*;
#(
    parameter int CW    = CNT_W,
    parameter int SHORT = SHORT_TICKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ctl_enable,
    input  logic              ctl_connect,
    input  logic              ctl_irq_en,
    input  logic              cfg_wr,
    input  logic [MULT_W-1:0] cfg_mult,
    input  logic [DIV_W-1:0]  cfg_prediv,
    input  logic              pwr_down,
    input  logic              ref_tick,
    input  logic              pll_lock_in,
    input  logic              ref_out_of_range,
    input  logic              ref_below_400k,
    input  logic [CW-1:0]     startup_ticks_long,
    output logic              clk_sel_pll,
    output logic              lock_irq,
    output logic [31:0]       status_word
);
    pls_regs_t  regs_q;
    pls_state_e state;
    logic       cfg_changed;
    logic       restart;
    logic       timer_done;
    logic       lock_ok;
    logic       acquiring, locked, connected;

    always_comb begin
        cfg_changed = (cfg_mult != regs_q.mult) || (cfg_prediv != regs_q.prediv);
        restart     = cfg_wr && cfg_changed;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            if (cfg_wr) begin
                regs_q.mult   <= cfg_mult;
                regs_q.prediv <= cfg_prediv;
            end
            if (pwr_down) begin
                regs_q.en   <= 1'b0;
                regs_q.conn <= 1'b0;
                if (ctl_wr) begin
                    regs_q.irq_en <= ctl_irq_en;
                end
            end else if (ctl_wr) begin
                regs_q.en     <= ctl_enable;
                regs_q.conn   <= ctl_connect;
                regs_q.irq_en <= ctl_irq_en;
            end
        end
    end

    pls_startup_timer #(
        .CW    (CW),
        .SHORT (SHORT)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (acquiring && regs_q.en),
        .clear      (restart),
        .tick       (ref_tick),
        .use_short  (ref_below_400k),
        .long_limit (startup_ticks_long),
        .done       (timer_done)
    );

    always_comb begin
        lock_ok = ref_out_of_range ? timer_done : pll_lock_in;
    end

    pls_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (regs_q.en),
        .conn        (regs_q.conn),
        .restart     (restart),
        .lock_ok     (lock_ok),
        .analog_mode (!ref_out_of_range),
        .state       (state),
        .acquiring   (acquiring),
        .locked      (locked),
        .connected   (connected)
    );

    always_comb begin
        clk_sel_pll = connected && regs_q.en && regs_q.conn && (state == ST_CONNECTED);
        lock_irq    = locked && regs_q.irq_en;
    end

    pls_status_pack u_pack (
        .mult   (regs_q.mult),
        .prediv (regs_q.prediv),
        .en     (regs_q.en),
        .conn   (regs_q.conn),
        .lock   (locked),
        .word   (status_word)
    );
endmodule

// File: rtl/pls_checker.sv
module pls_checker
    import pls_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_down,
    input logic              cfg_wr,
    input logic [MULT_W-1:0] cfg_mult,
    input logic [DIV_W-1:0]  cfg_prediv,
    input logic              clk_sel_pll,
    input logic              lock_irq,
    input logic [31:0]       status_word
);
    assert_sel_needs_all_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel_pll |-> (status_word[24] && status_word[25] && status_word[26]));

    assert_pwrdown_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (!status_word[24] && !status_word[25]));

    assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[15] == 1'b0) && (status_word[31:27] == 5'd0));

    assert_irq_needs_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_irq |-> status_word[26]);

    assert_disable_drops_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !status_word[24] |=> !status_word[26]);

    assert_cfg_change_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && ((cfg_mult != status_word[14:0]) || (cfg_prediv != status_word[23:16])))
        |=> !status_word[26]);
endmodule

bind pll_lock_supervisor pls_checker u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_down    (pwr_down),
    .cfg_wr      (cfg_wr),
    .cfg_mult    (cfg_mult),
    .cfg_prediv  (cfg_prediv),
    .clk_sel_pll (clk_sel_pll),
    .lock_irq    (lock_irq),
    .status_word (status_word)
);

// File: tb/pll_lock_supervisor_tb.sv
module pll_lock_supervisor_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 0, ctl_enable = 0, ctl_connect = 0, ctl_irq_en = 0;
    logic        cfg_wr = 0;
    logic [14:0] cfg_mult = '0;
    logic [7:0]  cfg_prediv = '0;
    logic        pwr_down = 0, ref_tick = 1, pll_lock_in = 0;
    logic        ref_out_of_range = 0, ref_below_400k = 0;
    logic [15:0] startup_ticks_long = 16'd50;
    logic        clk_sel_pll, lock_irq;
    logic [31:0] status_word;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    pll_lock_supervisor u_dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_enable(ctl_enable), .ctl_connect(ctl_connect), .ctl_irq_en(ctl_irq_en),
        .cfg_wr(cfg_wr), .cfg_mult(cfg_mult), .cfg_prediv(cfg_prediv),
        .pwr_down(pwr_down), .ref_tick(ref_tick), .pll_lock_in(pll_lock_in),
        .ref_out_of_range(ref_out_of_range), .ref_below_400k(ref_below_400k),
        .startup_ticks_long(startup_ticks_long),
        .clk_sel_pll(clk_sel_pll), .lock_irq(lock_irq), .status_word(status_word)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctl(input logic e, input logic c, input logic i);
        ctl_wr = 1; ctl_enable = e; ctl_connect = c; ctl_irq_en = i;
        cyc(1);
        ctl_wr = 0;
    endtask

    task automatic cfg(input logic [14:0] m, input logic [7:0] d);
        cfg_wr = 1; cfg_mult = m; cfg_prediv = d;
        cyc(1);
        cfg_wr = 0;
    endtask

    // {en, conn, irq_en, lock_in, exp_sel, exp_lock, exp_irq}
    localparam logic [6:0] VEC [9] = '{
        7'b0_1_0_1_0_0_0, // R2 connect without enable is off
        7'b1_0_1_0_0_0_0, // R6 waiting for lock
        7'b1_1_1_0_0_0_0, // R9 connect pending
        7'b1_1_1_1_1_1_1, // R9 R1 connect takes effect
        7'b1_1_0_1_1_1_0, // R5 mask
        7'b1_1_1_0_0_0_0, // R6 loss of lock
        7'b1_1_1_1_1_1_1, // R6 regained
        7'b1_0_1_1_0_1_1, // R1 connect withdrawn
        7'b0_0_1_1_0_0_0  // R8 disable
    };

    initial begin
        cyc(3);
        check("R4 reset status", status_word, 32'h0);
        check("R1 reset select", {31'd0, clk_sel_pll}, 32'd0);
        check("R5 reset irq", {31'd0, lock_irq}, 32'd0);
        rst_n = 1;
        cyc(1);

        foreach (VEC[k]) begin
            pll_lock_in = VEC[k][3];
            ctl(VEC[k][6], VEC[k][5], VEC[k][4]);
            cyc(4);
            check($sformatf("R1/R2/R5/R6/R9 vec%0d", k),
                  {29'd0, clk_sel_pll, status_word[26], lock_irq},
                  {29'd0, VEC[k][2:0]});
        end

        // R4 layout
        pll_lock_in = 1;
        cfg(15'h5A5A, 8'hC3);
        ctl(1, 1, 1);
        cyc(4);
        check("R4 layout", status_word, {5'd0, 3'b111, 8'hC3, 1'b0, 15'h5A5A});
        check("R1 connected", {31'd0, clk_sel_pll}, 32'd1);

        // R10 identical configuration
        cfg(15'h5A5A, 8'hC3);
        check("R10 same cfg lock", {31'd0, status_word[26]}, 32'd1);
        cyc(1);
        check("R10 same cfg select", {31'd0, clk_sel_pll}, 32'd1);

        // R8 changed configuration
        cfg(15'h0011, 8'hC3);
        check("R8 cfg change lock", {31'd0, status_word[26]}, 32'd0);
        check("R8 cfg change select", {31'd0, clk_sel_pll}, 32'd0);
        cyc(3);
        check("R8 relock", {31'd0, status_word[26]}, 32'd1);

        // R3 power-down beats a same-cycle write
        pwr_down = 1; ctl_wr = 1; ctl_enable = 1; ctl_connect = 1; ctl_irq_en = 1;
        cyc(1);
        pwr_down = 0; ctl_wr = 0;
        check("R3 pwrdown en/conn", {30'd0, status_word[25:24]}, 32'd0);
        check("R3 pwrdown select", {31'd0, clk_sel_pll}, 32'd0);
        cyc(2);
        check("R8 pwrdown lock", {31'd0, status_word[26]}, 32'd0);

        // R7 short start-up timer, analog lock held low
        ref_out_of_range = 1; ref_below_400k = 1; pll_lock_in = 0; ref_tick = 1;
        ctl(1, 1, 1);
        cyc(150);
        check("R7 short before limit", {31'd0, status_word[26]}, 32'd0);
        cyc(60);
        check("R7 short after limit", {31'd0, status_word[26]}, 32'd1);
        check("R7 short connects", {31'd0, clk_sel_pll}, 32'd1);
        check("R7 short irq", {31'd0, lock_irq}, 32'd1);

        // R7 long timer, analog lock held high but ignored
        ctl(0, 0, 1);
        cyc(2);
        ref_below_400k = 0; pll_lock_in = 1;
        ctl(1, 0, 1);
        cyc(30);
        check("R7 long ignores lock input", {31'd0, status_word[26]}, 32'd0);
        cyc(30);
        check("R7 long after limit", {31'd0, status_word[26]}, 32'd1);

        // R8 restart: disable part way, re-enable, count restarts
        ctl(0, 0, 1);
        cyc(2);
        ctl(1, 0, 1);
        cyc(40);
        ctl(0, 0, 1);
        cyc(2);
        ctl(1, 0, 1);
        cyc(30);
        check("R8 count restarted", {31'd0, status_word[26]}, 32'd0);

        // R7 no ticks, no lock
        ctl(0, 0, 1);
        cyc(2);
        ref_tick = 0;
        ctl(1, 0, 1);
        cyc(300);
        check("R7 no ticks", {31'd0, status_word[26]}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule